// File: doc/BRIEF.md
# Cartridge Bank-Switching Register File

This block sits between an 8-bit CPU and the memories of a plug-in cartridge. It watches CPU writes in the upper half of the address space and keeps a bank register, a mode register, three program-page registers and four pattern-page registers. From them it produces, with no extra delay, the page number for each of the four 8 KB program windows over 0x8000-0xFFFF, the page number for each of the four 2 KB pattern windows, and a nametable mirroring select.

Three program-banking layouts are chosen by two mode bits: four independent 8 KB windows sharing one outer page bit, one 32 KB block of consecutive pages, or a switchable 16 KB block followed by the last 16 KB of program memory. A low window at 0x5000-0x5FFF offers a read port that returns two configuration switch bits under an open-bus byte, and four byte-wide scratch registers.

Top module: `cart_bank_map`

## Requirements
- R1: After power-on reset every register is zero: program windows read 0, 1, P-2, P-1 (P = PRG_PAGES), all pattern windows read 0, `mirror_h` is 0, and all scratch bytes read 0.
- R2: Writes with `cpu_addr[15]`=1 are decoded on `cpu_addr & 0x8C17`; 0x8000 loads bank, 0x8400 loads mode, 0x8C00/0x8C01/0x8C02 load program registers 0/1/2, so any address aliasing to those values (such as 0xF3E8 to 0x8000) acts the same.
- R3: Writes whose masked address matches none of the nine loading values, and writes below 0x8000, change no page output and no mirroring select.
- R4: `mirror_h` equals mode bit 0 (1 = horizontal, 0 = vertical).
- R5: With mode bit 4 set, windows 0-2 equal (program register low nibble) OR (bank bit 3 placed at page bit 4); window 3 equals that outer bit OR 0x0F.
- R6: With mode bit 4 clear and bit 3 set, windows 0-3 equal B, B+1, B+2, B+3 where B = (bank AND 0xFE) x 2.
- R7: With mode bits 4 and 3 clear, windows 0-1 equal bank x 2 and bank x 2 + 1; windows 2-3 equal P-2 and P-1.
- R8: Pattern windows 0-3 equal the full bytes written to masked addresses 0x8C10, 0x8C11, 0x8C16, 0x8C17 respectively.
- R9: A read in 0x5000-0x53FF returns `open_bus[7:2]` in bits 7:2 and `dip_sw[1:0]` in bits 1:0.
- R10: Writes to 0x5000-0x53FF have no effect on any scratch byte or output.
- R11: In 0x5400-0x5FFF, reads and writes reach scratch byte `cpu_addr[1:0]`; all other address bits in that range are ignored.
- R12: A `soft_rst` pulse clears only the bank and mode registers; program, pattern and scratch contents are kept.
- R13: `cpu_rdata` is zero whenever `cpu_rd` is low or the address lies outside 0x5000-0x5FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Synchronous soft reset, clears bank and mode |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| open_bus | input | 8 | Last value seen on the CPU data bus |
| dip_sw | input | 2 | Configuration switch bits |
| cpu_rdata | output | 8 | Read data |
| prg_win0 | output | PAGE_W | 8 KB page for 0x8000-0x9FFF |
| prg_win1 | output | PAGE_W | 8 KB page for 0xA000-0xBFFF |
| prg_win2 | output | PAGE_W | 8 KB page for 0xC000-0xDFFF |
| prg_win3 | output | PAGE_W | 8 KB page for 0xE000-0xFFFF |
| chr_win0 | output | 8 | 2 KB pattern page, window 0 |
| chr_win1 | output | 8 | 2 KB pattern page, window 1 |
| chr_win2 | output | 8 | 2 KB pattern page, window 2 |
| chr_win3 | output | 8 | 2 KB pattern page, window 3 |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
A corrupted bank or mode register shows at the program window outputs on the very next cycle, because the page numbers are pure logic on the registers; a wrong layout choice shows as windows that break the consecutive-page or fixed-last-page pattern. A lost or misrouted write to a pattern or program register shows only when the affected window is read back in the layout that uses it, so each layout is exercised after the registers are loaded. Scratch corruption is invisible until the byte is read, so reads follow every write that could have disturbed it.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam logic [15:0] DEC_MASK  = 16'h8C17;
  localparam logic [15:0] A_BANK    = 16'h8000;
  localparam logic [15:0] A_MODE    = 16'h8400;
  localparam logic [15:0] A_PRG0    = 16'h8C00;
  localparam logic [15:0] A_PRG1    = 16'h8C01;
  localparam logic [15:0] A_PRG2    = 16'h8C02;
  localparam logic [15:0] A_CHR0    = 16'h8C10;
  localparam logic [15:0] A_CHR1    = 16'h8C11;
  localparam logic [15:0] A_CHR2    = 16'h8C16;
  localparam logic [15:0] A_CHR3    = 16'h8C17;
  localparam int          N_PRG_REG = 3;
  localparam int          N_WIN     = 4;
  localparam int          N_SCR     = 4;

  typedef struct packed {
    logic split8;   // mode bit 4
    logic whole32;  // mode bit 3
    logic horiz;    // mode bit 0
  } mode_t;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic [15:0]                   addr,
  input  logic [7:0]                    wdata,
  input  logic                          wr,
  output logic [7:0]                    bank_q,
  output mode_t                         mode_q,
  output logic [N_PRG_REG-1:0][3:0]     prg_q,
  output logic [N_WIN-1:0][7:0]         chr_q
);
  logic [7:0]                bank_d;
  mode_t                     mode_d;
  logic [N_PRG_REG-1:0][3:0] prg_d;
  logic [N_WIN-1:0][7:0]     chr_d;
  logic [15:0]               dec;

  assign dec = addr & DEC_MASK;

  always_comb begin
    bank_d = bank_q;
    mode_d = mode_q;
    prg_d  = prg_q;
    chr_d  = chr_q;
    if (soft_rst) begin
      bank_d = '0;
      mode_d = '0;
    end else if (wr && addr[15]) begin
      unique case (dec)
        A_BANK: bank_d = wdata;
        A_MODE: mode_d = '{split8: wdata[4], whole32: wdata[3], horiz: wdata[0]};
        A_PRG0: prg_d[0] = wdata[3:0];
        A_PRG1: prg_d[1] = wdata[3:0];
        A_PRG2: prg_d[2] = wdata[3:0];
        A_CHR0: chr_d[0] = wdata;
        A_CHR1: chr_d[1] = wdata;
        A_CHR2: chr_d[2] = wdata;
        A_CHR3: chr_d[3] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      mode_q <= '0;
      prg_q  <= '0;
      chr_q  <= '0;
    end else begin
      bank_q <= bank_d;
      mode_q <= mode_d;
      prg_q  <= prg_d;
      chr_q  <= chr_d;
    end
  end

  // R12
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank_q == 8'h00) && (mode_q == '0) && $stable(prg_q) && $stable(chr_q));

  // R3
  low_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr[15] && !soft_rst) |=> $stable(bank_q) && $stable(mode_q) && $stable(prg_q) && $stable(chr_q));
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int PRG_PAGES = 512,
  parameter int PAGE_W    = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [7:0]                    bank,
  input  mode_t                         mode,
  input  logic [N_PRG_REG-1:0][3:0]     prg,
  output logic [N_WIN-1:0][PAGE_W-1:0]  win
);
  localparam logic [PAGE_W-1:0] LAST = PAGE_W'(PRG_PAGES - 1);
  localparam logic [PAGE_W-1:0] PREV = PAGE_W'(PRG_PAGES - 2);

  logic [N_WIN-1:0][PAGE_W-1:0] win8;
  logic [PAGE_W-1:0]            outer;
  logic [PAGE_W-1:0]            base16;
  logic [PAGE_W-1:0]            base32;

  assign outer  = PAGE_W'({bank[3], 4'h0});
  assign base16 = PAGE_W'({bank, 1'b0});
  assign base32 = PAGE_W'({bank & 8'hFE, 1'b0});

  for (genvar w = 0; w < N_PRG_REG; w++) begin : g_split
    assign win8[w] = outer | PAGE_W'(prg[w]);
  end
  assign win8[N_WIN-1] = outer | PAGE_W'(4'hF);

  always_comb begin
    for (int w = 0; w < N_WIN; w++) begin
      if (mode.split8)       win[w] = win8[w];
      else if (mode.whole32) win[w] = base32 + PAGE_W'(w);
      else if (w < 2)        win[w] = base16 + PAGE_W'(w);
      else if (w == 2)       win[w] = PREV;
      else                   win[w] = LAST;
    end
  end

  // R5
  split_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode.split8 |-> (win[3][3:0] == 4'hF) && (win[0][4] == win[3][4]));

  // R6
  whole_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.split8 && mode.whole32) |-> (win[1] == win[0] + 1'b1) && (win[3] == win[2] + 1'b1) && (win[0][1:0] == 2'b00));

  // R7
  fixed_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.split8 && !mode.whole32) |-> (win[3] == win[2] + 1'b1) && (win[0][0] == 1'b0));
endmodule

// File: rtl/cbm_scratch.sv
module cbm_scratch
  import cbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_sw,
  input  logic        in_scr,
  input  logic [1:0]  idx,
  input  logic [7:0]  wdata,
  input  logic        wr,
  input  logic        rd,
  input  logic [7:0]  open_bus,
  input  logic [1:0]  dip,
  output logic [7:0]  rdata
);
  logic [N_SCR-1:0][7:0] scr_q;
  logic [N_SCR-1:0][7:0] scr_d;

  always_comb begin
    scr_d = scr_q;
    if (wr && in_scr) scr_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scr_q <= '0;
    else        scr_q <= scr_d;
  end

  always_comb begin
    rdata = 8'h00;
    if (rd && in_sw)       rdata = (open_bus & 8'hFC) | {6'b0, dip};
    else if (rd && in_scr) rdata = scr_q[idx];
  end

  // R10
  sw_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_sw) |=> $stable(scr_q));

  // R9
  sw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && in_sw) |-> (rdata[1:0] == dip) && (rdata[7:2] == open_bus[7:2]));

  // R13
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == 8'h00));
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cbm_pkg::*;
#(
  parameter int PRG_PAGES = 512,
  parameter int PAGE_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        open_bus,
  input  logic [1:0]        dip_sw,
  output logic [7:0]        cpu_rdata,
  output logic [PAGE_W-1:0] prg_win0,
  output logic [PAGE_W-1:0] prg_win1,
  output logic [PAGE_W-1:0] prg_win2,
  output logic [PAGE_W-1:0] prg_win3,
  output logic [7:0]        chr_win0,
  output logic [7:0]        chr_win1,
  output logic [7:0]        chr_win2,
  output logic [7:0]        chr_win3,
  output logic              mirror_h
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [7:0]                   bank_q;
  mode_t                        mode_q;
  logic [N_PRG_REG-1:0][3:0]    prg_q;
  logic [N_WIN-1:0][7:0]        chr_q;
  logic [N_WIN-1:0][PAGE_W-1:0] win;
  logic                         in_low, in_sw, in_scr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign in_low = (cpu_addr[15:12] == 4'h5);
  assign in_sw  = in_low && (cpu_addr[11:10] == 2'b00);
  assign in_scr = in_low && (cpu_addr[11:10] != 2'b00);

  cbm_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .soft_rst(soft_rst), .addr(cpu_addr),
    .wdata(cpu_wdata), .wr(cpu_wr), .bank_q(bank_q), .mode_q(mode_q),
    .prg_q(prg_q), .chr_q(chr_q)
  );

  cbm_prg_map #(.PRG_PAGES(PRG_PAGES), .PAGE_W(PAGE_W)) u_map (
    .clk(clk), .rst_n(rst_int_n), .bank(bank_q), .mode(mode_q),
    .prg(prg_q), .win(win)
  );

  cbm_scratch u_scr (
    .clk(clk), .rst_n(rst_int_n), .in_sw(in_sw), .in_scr(in_scr),
    .idx(cpu_addr[1:0]), .wdata(cpu_wdata), .wr(cpu_wr), .rd(cpu_rd),
    .open_bus(open_bus), .dip(dip_sw), .rdata(cpu_rdata)
  );

  assign prg_win0 = win[0];
  assign prg_win1 = win[1];
  assign prg_win2 = win[2];
  assign prg_win3 = win[3];
  assign chr_win0 = chr_q[0];
  assign chr_win1 = chr_q[1];
  assign chr_win2 = chr_q[2];
  assign chr_win3 = chr_q[3];
  assign mirror_h = mode_q.horiz;

  // R4
  mirror_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && ((cpu_addr & DEC_MASK) == A_MODE) && !soft_rst) |=> (mirror_h == $past(cpu_wdata[0])));

  // R13
  outside_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_low |-> (cpu_rdata == 8'h00));
endmodule

// File: tb/sim_cart_bank_map.sv
module sim_cart_bank_map;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 512;
  localparam int PW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [15:0]   cpu_addr = 16'h0000;
  logic [7:0]    cpu_wdata = 8'h00;
  logic          cpu_wr = 1'b0;
  logic          cpu_rd = 1'b0;
  logic [7:0]    open_bus = 8'h00;
  logic [1:0]    dip_sw = 2'b00;
  logic [7:0]    cpu_rdata;
  logic [PW-1:0] pw0, pw1, pw2, pw3;
  logic [7:0]    cw0, cw1, cw2, cw3;
  logic          mirror_h;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_map #(.PRG_PAGES(P), .PAGE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .open_bus(open_bus),
    .dip_sw(dip_sw), .cpu_rdata(cpu_rdata), .prg_win0(pw0), .prg_win1(pw1),
    .prg_win2(pw2), .prg_win3(pw3), .chr_win0(cw0), .chr_win1(cw1),
    .chr_win2(cw2), .chr_win3(cw3), .mirror_h(mirror_h)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic check_prg(string req, int e0, int e1, int e2, int e3);
    check(req, 32'(pw0), 32'(e0));
    check(req, 32'(pw1), 32'(e1));
    check(req, 32'(pw2), 32'(e2));
    check(req, 32'(pw3), 32'(e3));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check_prg("R1", 0, 1, P-2, P-1);
    check("R1 chr", {cw0, cw1, cw2, cw3}, 32'h0);
    check("R1 mirror", 32'(mirror_h), 32'h0);
    rd(16'h5402, d);
    check("R1 scratch", 32'(d), 32'h0);
  endtask

  task automatic t_sixteen();
    wr(16'hF3E8, 8'h05);               // aliases to bank load
    check_prg("R2 R7", 10, 11, P-2, P-1);
    wr(16'h8000, 8'hFF);
    check_prg("R7 top bank", 510, 511, P-2, P-1);
  endtask

  task automatic t_mirror();
    wr(16'h8400, 8'h01);
    check("R4 horiz", 32'(mirror_h), 32'h1);
    wr(16'h8400, 8'h00);
    check("R4 vert", 32'(mirror_h), 32'h0);
  endtask

  task automatic t_whole();
    wr(16'h8000, 8'h07);
    wr(16'h8400, 8'h08);
    check_prg("R6", 12, 13, 14, 15);
    wr(16'h8000, 8'h0A);
    check_prg("R6 even", 20, 21, 22, 23);
  endtask

  task automatic t_split();
    wr(16'h8C00, 8'h23);
    wr(16'hFFE9, 8'h05);               // aliases to program register 1
    wr(16'h8C02, 8'hFA);
    wr(16'h8000, 8'h08);
    wr(16'h8400, 8'h18);               // bit 4 wins over bit 3
    check_prg("R5 outer", 8'h13, 8'h15, 8'h1A, 8'h1F);
    wr(16'h8000, 8'h00);
    check_prg("R5 no outer", 8'h03, 8'h05, 8'h0A, 8'h0F);
  endtask

  task automatic t_chr();
    wr(16'h8C10, 8'hA1);
    wr(16'h8C11, 8'hB2);
    wr(16'h8C16, 8'hC3);
    wr(16'hFFFF, 8'hD4);               // masks to 0x8C17
    check("R8", {cw0, cw1, cw2, cw3}, 32'hA1B2C3D4);
  endtask

  task automatic t_ignored();
    wr(16'h8C03, 8'h77);
    wr(16'h8804, 8'h77);
    wr(16'h8800, 8'h77);
    wr(16'h6000, 8'h77);
    check_prg("R3", 8'h03, 8'h05, 8'h0A, 8'h0F);
    check("R3 chr", {cw0, cw1, cw2, cw3}, 32'hA1B2C3D4);
    check("R3 mirror", 32'(mirror_h), 32'h0);
  endtask

  task automatic t_low();
    logic [7:0] d;
    open_bus = 8'hB6; dip_sw = 2'b01;
    rd(16'h5000, d);
    check("R9", 32'(d), 32'hB5);
    dip_sw = 2'b10; open_bus = 8'h4F;
    rd(16'h53FF, d);
    check("R9 top", 32'(d), 32'h4E);
    wr(16'h5401, 8'h3C);
    wr(16'h5FFE, 8'h99);
    rd(16'h5A05, d);
    check("R11 alias", 32'(d), 32'h3C);
    rd(16'h5402, d);
    check("R11 idx2", 32'(d), 32'h99);
    wr(16'h5001, 8'hEE);
    wr(16'h5102, 8'hEE);
    rd(16'h5401, d);
    check("R10 s1", 32'(d), 32'h3C);
    rd(16'h5402, d);
    check("R10 s2", 32'(d), 32'h99);
    check_prg("R10 prg", 8'h03, 8'h05, 8'h0A, 8'h0F);
    @(negedge clk);
    cpu_addr = 16'h5401;
    #1 check("R13 no strobe", 32'(cpu_rdata), 32'h0);
    cpu_addr = 16'h8000; cpu_rd = 1'b1;
    #1 check("R13 outside", 32'(cpu_rdata), 32'h0);
    cpu_rd = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic t_soft();
    logic [7:0] d;
    wr(16'h8000, 8'h08);
    wr(16'h8400, 8'h11);
    check("R12 pre", 32'(mirror_h), 32'h1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check_prg("R12", 0, 1, P-2, P-1);
    check("R12 mirror", 32'(mirror_h), 32'h0);
    check("R12 chr", {cw0, cw1, cw2, cw3}, 32'hA1B2C3D4);
    rd(16'h5401, d);
    check("R12 scratch", 32'(d), 32'h3C);
    wr(16'h8400, 8'h10);
    check_prg("R12 prg kept", 8'h03, 8'h05, 8'h0A, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sixteen();
    t_mirror();
    t_whole();
    t_split();
    t_chr();
    t_ignored();
    t_low();
    t_soft();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule